// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-driven master for the two-wire management bus that connects a MAC to its Ethernet PHYs. A host programs a control register with a 5-bit PHY address, a 5-bit register address and one command bit. The block then sends a complete clause-22 management frame on MDC/MDIO and clears the command bit by itself when the frame ends. For a write, the 16-bit data register supplies the frame's data field. For a read, the 16 bits returned by the PHY land in that same data register. A flag records whether any PHY pulled the line low in the turnaround slot.

MDC is derived from the system clock through a parameterised half-period divider, and MDC stays low between frames. MDIO is presented as a separate output value and output enable, so the tri-state buffer sits outside the block. A busy output stays high for the whole frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word (`reg_sel`=0) and the data word (`reg_sel`=1) both read 0, MDC is low, `mdio_oe` is 0 and `busy` is 0.
- R2: The control word holds the PHY address in bits 13..9 (MSB at 13) and the register address in bits 8..4 (MSB at 8). Both read back as written. Bits 31..14 and bit 2 always read 0.
- R3: Every frame is 64 bits, sent MSB first on each field: 32 ones, start code 01, opcode (01 write, 10 read), the PHY address, then the register address.
- R4: A write frame (control bit 1) then drives turnaround 10 and the 16 bits of the data register. MDIO is driven for all 64 bit times.
- R5: A read frame (control bit 0) releases MDIO (`mdio_oe`=0) from bit 46 to the end. It samples the 16 data bits (bits 48..63) on MDC rising edges, MSB first, and stores them in the data register when the frame ends.
- R6: Each bit lasts 2*DIV_HALF system clocks: MDC is low for the first DIV_HALF clocks and high for the rest. MDIO and its enable change only while MDC is low, so they never change while MDC is high.
- R7: The command bit that started a frame reads 1 for the whole frame and returns to 0 in the cycle the frame ends.
- R8: Control bit 3 reads 1 after a read frame if MDIO was low at the MDC rising edge of bit 47 (the second turnaround slot), and reads 0 otherwise. It is cleared when any frame starts, so it reads 0 after a write frame.
- R9: Writing both command bits together starts a read frame only, and only bit 0 reads as set.
- R10: While `busy` is 1, host writes to the control word and to the data word are ignored. Fields, command bits and data keep their values.
- R11: `busy` rises on the clock after a command write and stays high for exactly 64*2*DIV_HALF clocks. When it falls, MDIO is released and MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the data word |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read value of the selected word |
| busy | output | 1 | High while a frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable (0 means high impedance) |
| mdio_i | input | 1 | Sampled MDIO line level |

## Verification
The hardest case to reach is the responder flag. It depends on one line level in a single clock, at the rising edge of the second turnaround bit, while the master has already released the line. The bench's PHY model drives the line from the reference model's own bit position. It answers with a low turnaround and a chosen data word in some reads, and stays silent (line pulled high) in others. A write that follows a responded read then shows that the flag clears. Host writes issued in the middle of a frame cover the rule that writes during a busy frame are ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int ACK_IDX    = 47;   // slot where a PHY pulls the line low
    localparam int DATA_IDX   = 48;   // first data bit
    localparam int DATA_W     = 16;
    localparam int FLD_W      = 5;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [FLD_W-1:0] phy;
        logic [FLD_W-1:0] regad;
    } mdio_target_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_op_e          op,
        input mdio_target_t      tgt,
        input logic [DATA_W-1:0] wdata
    );
        return {32'hFFFF_FFFF, 2'b01, op, tgt.phy, tgt.regad, 2'b10, wdata};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int unsigned DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == LAST);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  start_read,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  rise_stb,
    input  logic                  fall_stb,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  done,
    output logic                  is_read,
    output logic [IDX_W-1:0]      bit_idx,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  responded,
    output logic [DATA_W-1:0]     rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      nxt_idx;

    assign nxt_idx = bit_idx + 1'b1;
    assign done    = busy && fall_stb && (bit_idx == LAST_IDX);
    assign mdio_o  = shreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            is_read   <= 1'b0;
            bit_idx   <= '0;
            shreg     <= '0;
            mdio_oe   <= 1'b0;
            responded <= 1'b0;
            rd_data   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                is_read   <= start_read;
                bit_idx   <= '0;
                shreg     <= frame;
                mdio_oe   <= 1'b1;
                responded <= 1'b0;
            end
        end else begin
            if (rise_stb && is_read) begin
                if (bit_idx == IDX_W'(ACK_IDX))
                    responded <= !mdio_i;
                if (bit_idx >= IDX_W'(DATA_IDX))
                    rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (bit_idx == LAST_IDX) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    shreg   <= '0;
                    bit_idx <= '0;
                end else begin
                    bit_idx <= nxt_idx;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                    mdio_oe <= !(is_read && (nxt_idx >= IDX_W'(TA_IDX)));
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic                  reg_sel,
    input  logic [31:0]           reg_wdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic                  responded,
    input  logic [DATA_W-1:0]     rd_data,
    output logic [31:0]           reg_rdata,
    output logic                  start,
    output logic                  start_read,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  rd_cmd,
    output logic                  wr_cmd
);
    mdio_target_t      tgt_q, tgt_new;
    logic [DATA_W-1:0] data_q;
    logic              ctrl_wr, data_wr;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[31:16], reg_wdata[3:2]};

    assign ctrl_wr    = reg_wr_en && !reg_sel && !busy;
    assign data_wr    = reg_wr_en &&  reg_sel && !busy;
    assign tgt_new    = '{phy: reg_wdata[13:9], regad: reg_wdata[8:4]};
    assign start      = ctrl_wr && (reg_wdata[0] || reg_wdata[1]);
    assign start_read = reg_wdata[0];
    assign frame      = build_frame(start_read ? OP_READ : OP_WRITE, tgt_new, data_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            data_q <= '0;
            rd_cmd <= 1'b0;
            wr_cmd <= 1'b0;
        end else begin
            if (ctrl_wr)
                tgt_q <= tgt_new;
            if (start) begin
                rd_cmd <= reg_wdata[0];
                wr_cmd <= !reg_wdata[0];
            end else if (done) begin
                rd_cmd <= 1'b0;
                wr_cmd <= 1'b0;
            end
            if (data_wr)
                data_q <= reg_wdata[DATA_W-1:0];
            else if (done && rd_cmd)
                data_q <= rd_data;
        end
    end

    always_comb begin
        if (reg_sel)
            reg_rdata = {{(32-DATA_W){1'b0}}, data_q};
        else
            reg_rdata = {18'b0, tgt_q.phy, tgt_q.regad, responded, 1'b0, wr_cmd, rd_cmd};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                  rise_stb, fall_stb;
    logic                  start, start_read, done;
    logic                  eng_is_read, responded;
    logic                  rd_cmd, wr_cmd;
    logic [IDX_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] frame;
    logic [DATA_W-1:0]     rd_data;

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk(clk), .rst(rst), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .start_read(start_read),
        .frame(frame), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .mdio_i(mdio_i), .busy(busy), .done(done), .is_read(eng_is_read),
        .bit_idx(bit_idx), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .responded(responded), .rd_data(rd_data)
    );

    mdio_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .done(done),
        .responded(responded), .rd_data(rd_data), .reg_rdata(reg_rdata),
        .start(start), .start_read(start_read), .frame(frame),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd)
    );
endmodule

// File: rtl/mdio_master_checks.sv
module mdio_master_checks
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic             is_read,
    input logic [IDX_W-1:0] bit_idx
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_mdio_steady_R6: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_cmd_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd || wr_cmd) == busy);

    assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_cmd, wr_cmd}));

    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && is_read && (bit_idx >= IDX_W'(TA_IDX))) |-> !mdio_oe);

    assert_write_driven_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_read) |-> mdio_oe);
endmodule

bind mdio_master mdio_master_checks u_chk (
    .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .is_read(eng_is_read), .bit_idx(bit_idx)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int D     = 4;
    localparam int TOTAL = 64 * 2 * D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = !clk;

    mdio_master #(.DIV_HALF(D)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // reference model state
    int          mk = -1;
    logic        m_rd = 1'b0;
    logic        m_resp = 1'b0;
    logic [4:0]  m_phy = '0;
    logic [4:0]  m_reg = '0;
    logic [15:0] m_data = '0;
    logic [15:0] m_shift = '0;
    logic [63:0] m_frame = '0;

    // PHY model
    logic        phy_on = 1'b0;
    logic [15:0] phy_word = '0;

    always_comb begin
        mdio_i = 1'b1;
        if (phy_on && mk >= 0) begin
            if (mk / (2 * D) == 47)
                mdio_i = 1'b0;
            else if (mk / (2 * D) >= 48)
                mdio_i = phy_word[63 - mk / (2 * D)];
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            mk <= -1; m_rd <= 0; m_resp <= 0; m_phy <= 0; m_reg <= 0;
            m_data <= 0; m_shift <= 0; m_frame <= 0;
        end else if (mk < 0) begin
            if (reg_wr_en && !reg_sel) begin
                m_phy <= reg_wdata[13:9];
                m_reg <= reg_wdata[8:4];
                if (reg_wdata[0] || reg_wdata[1]) begin
                    mk      <= 0;
                    m_rd    <= reg_wdata[0];
                    m_resp  <= 1'b0;
                    m_frame <= {32'hFFFF_FFFF, 2'b01,
                                reg_wdata[0] ? 2'b10 : 2'b01,
                                reg_wdata[13:9], reg_wdata[8:4], 2'b10, m_data};
                end
            end else if (reg_wr_en && reg_sel) begin
                m_data <= reg_wdata[15:0];
            end
        end else begin
            if ((mk % (2 * D)) == D - 1 && m_rd) begin
                if (mk / (2 * D) == 47) m_resp <= !mdio_i;
                if (mk / (2 * D) >= 48) m_shift <= {m_shift[14:0], mdio_i};
            end
            if (mk == TOTAL - 1) begin
                mk <= -1;
                if (m_rd) m_data <= m_shift;
            end else begin
                mk <= mk + 1;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic e_busy, e_mdc, e_oe, e_bit, a_bit;
            logic [31:0] e_rd;
            e_busy = (mk >= 0);
            e_mdc  = (mk >= 0) ? (((mk / D) % 2) == 1) : 1'b0;
            e_oe   = (mk >= 0) ? (m_rd ? (mk / (2 * D) < 46) : 1'b1) : 1'b0;
            e_bit  = e_oe ? m_frame[63 - mk / (2 * D)] : 1'b0;
            a_bit  = e_oe ? mdio_o : 1'b0;
            e_rd   = reg_sel ? {16'b0, m_data}
                             : {18'b0, m_phy, m_reg, m_resp, 1'b0,
                                e_busy && !m_rd, e_busy && m_rd};
            chk("R3 R4 R5 R6 R11", "per-clock {busy,mdc,oe,mdio,rdata}",
                {27'b0, busy, mdc, mdio_oe, a_bit, reg_rdata},
                {27'b0, e_busy, e_mdc, e_oe, e_bit, e_rd});
        end
    end

    task automatic host_wr(input logic sel, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic sel, output logic [31:0] v);
        @(posedge clk); #1;
        reg_sel = sel;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(input logic [4:0] p, input logic [4:0] r,
                                        input logic [1:0] cmd);
        return {18'b0, p, r, 2'b00, cmd};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int t0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        host_rd(1'b0, v); chk("R1", "control after reset", v, 0);
        host_rd(1'b1, v); chk("R1", "data after reset", v, 0);
        chk("R1", "mdc/oe/busy after reset", {mdc, mdio_oe, busy}, 0);

        // R2 field placement and unused bits
        host_wr(1'b0, 32'hFFFF_FFFC);
        host_rd(1'b0, v); chk("R2", "all fields set, unused zero", v, 32'h0000_3FF0);
        host_wr(1'b0, ctl(5'h11, 5'h06, 2'b00));
        host_rd(1'b0, v); chk("R2", "phy 11 reg 06", v, 32'h0000_2260);

        // R4 write frame, R10 ignored writes, R11 busy length
        host_wr(1'b1, 32'h0000_A5C3);
        host_wr(1'b0, ctl(5'h0A, 5'h13, 2'b10));
        t0 = 0;
        repeat (100) @(posedge clk);
        host_rd(1'b0, v); chk("R7", "write bit set mid-frame", v[1:0], 2'b10);
        host_wr(1'b1, 32'h0000_1234);
        host_wr(1'b0, ctl(5'h01, 5'h01, 2'b01));
        host_rd(1'b0, v); chk("R10", "control kept during busy", v, ctl(5'h0A, 5'h13, 2'b10));
        wait_idle();
        host_rd(1'b0, v); chk("R7", "write bit self-cleared", v, ctl(5'h0A, 5'h13, 2'b00));
        host_rd(1'b1, v); chk("R10", "data kept during busy", v, 32'h0000_A5C3);

        // R11 busy duration
        host_wr(1'b0, ctl(5'h03, 5'h04, 2'b10));
        t0 = 0;
        @(negedge clk);
        while (busy) begin t0++; @(negedge clk); end
        chk("R11", "busy cycles", t0, TOTAL);
        chk("R11", "released after frame", {mdc, mdio_oe}, 0);

        // R5 R8 read with responding PHY
        phy_on = 1'b1; phy_word = 16'hBEEF;
        host_wr(1'b0, ctl(5'h01, 5'h02, 2'b01));
        repeat (50) @(posedge clk);
        host_rd(1'b0, v); chk("R7", "read bit set mid-frame", v[1:0], 2'b01);
        wait_idle();
        host_rd(1'b1, v); chk("R5", "read data stored", v, 32'h0000_BEEF);
        host_rd(1'b0, v); chk("R8", "responder set, read bit cleared", v, ctl(5'h01, 5'h02, 2'b00) | 32'h8);

        // R8 write after responded read clears flag
        host_wr(1'b0, ctl(5'h01, 5'h02, 2'b10));
        wait_idle();
        host_rd(1'b0, v); chk("R8", "responder cleared by write", v[3], 0);

        // R8 read with no PHY
        phy_on = 1'b0;
        host_wr(1'b0, ctl(5'h1F, 5'h00, 2'b01));
        wait_idle();
        host_rd(1'b0, v); chk("R8", "no responder", v[3], 0);
        host_rd(1'b1, v); chk("R5", "pulled-up data", v, 32'h0000_FFFF);

        // R9 both command bits
        phy_on = 1'b1; phy_word = 16'h0F0F;
        host_wr(1'b0, ctl(5'h05, 5'h1A, 2'b11));
        repeat (20) @(posedge clk);
        host_rd(1'b0, v); chk("R9", "only read bit set", v[1:0], 2'b01);
        wait_idle();
        host_rd(1'b1, v); chk("R9", "read performed", v, 32'h0000_0F0F);
        host_rd(1'b0, v); chk("R9", "responder after dual command", v[3], 1);

        repeat (10) @(posedge clk);
        finish_run();
    end
endmodule